// File: doc/BRIEF.md
# Idle Power-Down Timer

This block watches a host bus for signs of life and raises a power-down request once the bus has been quiet for a programmable time. Noncritical signals elsewhere in the chip can use that request to power themselves down. The timeout is built in two stages. A free-running prescaler of `PRESCALE_W` bits sets the coarse unit, which is 2^27 clock cycles by default. An 8-bit count then says how many of those units make up the timeout. A 20 MHz clock with a count of 1 gives roughly 6.7 seconds.

Each cycle of the `act_i` strobe counts as host activity and restarts both stages. A write to the count register, at configuration index `CFG_INDEX` (default 8'h2A), also restarts both stages. Either event drops the request on the next clock edge. A count of zero turns the timer off. A bench can make `PRESCALE_W` small so that expiry can be seen in a short run.

Top module: `idle_pd_timer`

## Requirements
- R1: After reset, `pwr_down_o` is 0 and the count register reads 0.
- R2: A read with `cfg_addr_i` equal to `CFG_INDEX` returns the stored count on `cfg_rdata_o`. Any other address returns 0.
- R3: A write (`cfg_we_i`=1) at `CFG_INDEX` loads `cfg_wdata_i` and restarts the timeout from zero. A write at any other address changes neither the count nor the timing.
- R4: With a nonzero count N and no restart, `pwr_down_o` rises at exactly the N×2^PRESCALE_W-th rising edge after the edge of the last restart.
- R5: When `act_i` is sampled high, `pwr_down_o` is 0 after that edge and both stages restart from zero.
- R6: With a count of 0, `pwr_down_o` is never asserted.
- R7: Once asserted, `pwr_down_o` stays high until activity, a write at `CFG_INDEX`, or reset. It neither wraps nor re-triggers.
- R8: Activity in the very last cycle before expiry pushes the expiry out by the full interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_i | input | 1 | Host bus activity strobe, one restart per high cycle |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 8 | Configuration index |
| cfg_wdata_i | input | VAL_W | Configuration write data |
| cfg_rdata_o | output | VAL_W | Configuration read data (combinational) |
| pwr_down_o | output | 1 | Power-down request for noncritical signals |

## Verification
Random rounds program counts from 0 to 4 and then run idle stretches that are sometimes broken by activity strobes. A reference count of idle edges tells an interval that is off by one from a correct one, and tells a timer that is merely disabled from one that has stalled. Directed cases put activity one cycle before expiry and set the count to zero. They also send writes to a neighbouring index, which separates a real restart from a spurious one. Reads at the matching index and at other indices show whether the address is decoded.

// File: rtl/idle_pd_timer.sv
module idle_pd_timer #(
  parameter int          PRESCALE_W = 27,
  parameter int          VAL_W      = 8,
  parameter logic [7:0]  CFG_INDEX  = 8'h2A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             cfg_we_i,
  input  logic [7:0]       cfg_addr_i,
  input  logic [VAL_W-1:0] cfg_wdata_i,
  output logic [VAL_W-1:0] cfg_rdata_o,
  output logic             pwr_down_o
);
  localparam logic [PRESCALE_W-1:0] PS_LAST = {PRESCALE_W{1'b1}};
  localparam logic [VAL_W-1:0]      ONE     = VAL_W'(1);

  logic [PRESCALE_W-1:0] pre_q;
  logic [VAL_W-1:0]      tick_q, val_q;
  logic                  pd_q;

  wire hit     = cfg_we_i && (cfg_addr_i == CFG_INDEX);
  wire restart = act_i || hit;
  wire armed   = (val_q != '0) && !pd_q;
  wire tick    = armed && (pre_q == PS_LAST);
  wire expire  = tick && (tick_q == val_q - ONE);

  assign cfg_rdata_o = (cfg_addr_i == CFG_INDEX) ? val_q : '0;
  assign pwr_down_o  = pd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      tick_q <= '0;
      val_q  <= '0;
      pd_q   <= 1'b0;
    end else if (restart) begin
      pre_q  <= '0;
      tick_q <= '0;
      pd_q   <= 1'b0;
      if (hit) val_q <= cfg_wdata_i;
    end else if (armed) begin
      pre_q <= pre_q + 1'b1;
      if (expire)    pd_q   <= 1'b1;
      else if (tick) tick_q <= tick_q + ONE;
    end
  end

  p_act_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |=> !pwr_down_o);
  p_zero_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (val_q == '0) |-> !pd_q);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_q && !act_i && !hit) |=> pd_q);
  p_rise_on_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_q) |-> ($past(pre_q) == PS_LAST));
  p_tick_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (val_q != '0) |-> (tick_q < val_q));
endmodule

// File: tb/test_idle_pd_timer.sv
module test_idle_pd_timer;
  localparam int PW = 4;
  localparam int PS = 1 << PW;
  localparam logic [7:0] IDX = 8'h2A;

  logic clk = 0, rst_n = 0, act = 0, we = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic [7:0] rdata;
  logic pd;
  int total = 0, bad = 0;
  int idle = 0, mval = 0;

  always #2.5 clk = ~clk;

  idle_pd_timer #(.PRESCALE_W(PW), .VAL_W(8), .CFG_INDEX(IDX)) i_idle_pd_timer (
    .clk(clk), .rst_n(rst_n), .act_i(act), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .pwr_down_o(pd));

  function automatic bit exp_pd(int v, int i);
    return (v != 0) && (i >= v * PS);
  endfunction

  task automatic chk(string tag, int act_v, int exp_v);
    total++;
    if (act_v != exp_v) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  task automatic cyc(bit a, bit w, logic [7:0] ad, logic [7:0] d, string tag);
    act = a; we = w; addr = ad; wdata = d;
    @(posedge clk);
    if (w && ad == IDX) mval = d;
    if (a || (w && ad == IDX)) idle = 0; else idle++;
    @(negedge clk);
    act = 0; we = 0;
    chk(tag, pd, exp_pd(mval, idle));
  endtask

  task automatic idle_n(int n, string tag);
    for (int k = 0; k < n; k++) cyc(0, 0, 8'h00, 8'h00, tag);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    addr = IDX;
    #1;
    chk("R1 pd", pd, 0);
    chk("R1 rdata", rdata, 0);
    idle_n(40, "R6 reset count zero");

    cyc(0, 1, IDX, 8'd3, "R3 write");
    addr = IDX; #1; chk("R2 read hit", rdata, 3);
    addr = 8'h2B; #1; chk("R2 read miss", rdata, 0);
    idle_n(3 * PS - 2, "R4 before expiry");
    cyc(0, 0, 8'h00, 8'h00, "R4 last quiet edge");
    cyc(0, 0, 8'h00, 8'h00, "R4 expiry edge");
    chk("R4 pd high", pd, 1);
    idle_n(200, "R7 hold no wrap");
    cyc(0, 1, 8'h2B, 8'd1, "R3 other index ignored");
    addr = IDX; #1; chk("R3 value kept", rdata, 3);
    chk("R3 pd kept", pd, 1);
    cyc(1, 0, 8'h00, 8'h00, "R5 activity clears");
    chk("R5 pd low", pd, 0);

    cyc(0, 1, IDX, 8'd2, "R3 write 2");
    idle_n(2 * PS - 1, "R8 approach");
    cyc(1, 0, 8'h00, 8'h00, "R8 late activity");
    idle_n(2 * PS - 1, "R8 deferred");
    chk("R8 still low", pd, 0);
    cyc(0, 0, 8'h00, 8'h00, "R8 full interval");
    chk("R8 now high", pd, 1);
    cyc(0, 1, IDX, 8'd0, "R6 write zero");
    idle_n(6 * PS, "R6 disabled");

    for (int r = 0; r < 40; r++) begin
      int v = $urandom_range(0, 4);
      int n = v * PS + $urandom_range(0, 30);
      cyc(0, 1, IDX, 8'(v), "R3 random write");
      addr = IDX; #1; chk("R2 random read", rdata, v);
      for (int k = 0; k < n; k++) begin
        bit a = ($urandom_range(0, 59) == 0);
        bit w = ($urandom_range(0, 49) == 0);
        cyc(a, w, 8'h2B, 8'(v + 1), a ? "R5 random act" : "R4 random idle");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule